// File: doc/BRIEF.md
# E1 Multiframe AIS Detector

This block watches the signalling timeslot of an E1 stream that runs with channel-associated signalling multiframing. It raises an alarm when that timeslot carries an almost all-ones pattern for a sustained period. An upstream framer supplies serial receive data with a bit strobe. The framer also supplies a flag marking timeslot-16 bits, a strobe on the last bit of each multiframe, and a strobe on loss of multiframe alignment. A mode input says whether CAS multiframing is in use.

For each multiframe, the block counts the zero bits among the 128 timeslot-16 bits. A multiframe is sparse when it holds at most three zeros. The alarm is declared once two sparse multiframes follow one another. The alarm is withdrawn at the close of the first multiframe that holds four or more zeros. The alarm state is presented as a live status bit. A separate one-cycle pulse marks each change of that state, for interrupt logic.

Top module: `e1_mais_det`

## Requirements
- R1: While `rst_ni` is low, `alarm_o` and `alarm_chg_o` are 0.
- R2: A bit is counted as a zero only when `bit_vld_i` is 1, `ts16_i` is 1 and `bit_i` is 0. Zeros outside timeslot 16, and cycles with `bit_vld_i` low, do not affect the alarm.
- R3: A multiframe is sparse when it contains 0 to 3 counted zeros, including any zero on the `mf_end_i` cycle itself. A multiframe with 4 zeros is not sparse.
- R4: `alarm_o` goes to 1 in the cycle after an `mf_end_i` that closes the second of two consecutive sparse multiframes. A single sparse multiframe does not set it.
- R5: `alarm_o` goes to 0 in the cycle after an `mf_end_i` that closes a multiframe which is not sparse.
- R6: While `cas_en_i` is 0, `alarm_o` is 0 from the next cycle on. The zero count and the run history are cleared, so after CAS returns, two further sparse multiframes are needed to set the alarm.
- R7: `mf_loss_i` (with `cas_en_i` high) clears the zero count and the run history, and leaves `alarm_o` unchanged. It takes priority over an `mf_end_i` in the same cycle, which is then discarded.
- R8: `alarm_chg_o` is 1 for exactly one cycle, in each cycle where `alarm_o` differs from its value in the previous cycle, and is 0 otherwise.
- R9: The zero count does not wrap. A multiframe whose 128 timeslot-16 bits are all zero is not sparse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_en_i | input | 1 | CAS multiframing selected; 0 disables detection |
| bit_vld_i | input | 1 | Receive bit strobe |
| bit_i | input | 1 | Receive data bit |
| ts16_i | input | 1 | Current bit belongs to timeslot 16 |
| mf_end_i | input | 1 | Last bit of a multiframe |
| mf_loss_i | input | 1 | Loss of multiframe alignment strobe |
| alarm_o | output | 1 | Multiframe AIS alarm status |
| alarm_chg_o | output | 1 | One-cycle pulse on each alarm change |

## Verification
A wrong zero count or run history stays hidden until the next multiframe boundary. It shows at the ports one cycle after `mf_end_i`, as an alarm that is set or cleared wrongly. A saturation fault therefore needs a multiframe rich in zeros. A history that was not cleared needs a single sparse multiframe right after a loss or a CAS-off period. A fault in the change pulse shows in the same cycle as the alarm edge. The bench therefore compares both outputs on every clock, so any of these faults is caught at its first visible cycle.

// File: rtl/e1_mais_pkg.sv
package e1_mais_pkg;
  typedef struct packed {
    logic zero_hit;  // counted zero this cycle
    logic eval;      // close multiframe
    logic hist_clr;  // clear count and run history
    logic hard_clr;  // force alarm off
  } mais_ctl_t;
endpackage

// File: rtl/e1_mais_gate.sv
module e1_mais_gate
  import e1_mais_pkg::*;
(
  input  logic      cas_en_i,
  input  logic      bit_vld_i,
  input  logic      bit_i,
  input  logic      ts16_i,
  input  logic      mf_end_i,
  input  logic      mf_loss_i,
  output mais_ctl_t ctl_o
);
  logic live;
  assign live           = cas_en_i & ~mf_loss_i;
  assign ctl_o.zero_hit = live & bit_vld_i & ts16_i & ~bit_i;
  assign ctl_o.eval     = live & mf_end_i;
  assign ctl_o.hist_clr = ~live;
  assign ctl_o.hard_clr = ~cas_en_i;
endmodule

// File: rtl/e1_mais_zcnt.sv
module e1_mais_zcnt #(
  parameter int ZERO_MAX = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_hit_i,
  input  logic eval_i,
  input  logic clr_i,
  output logic sparse_o
);
  localparam int SAT = ZERO_MAX + 1;
  localparam int CW  = $clog2(SAT + 1);

  logic [CW-1:0] cnt_q, cnt_sum;

  always_comb begin
    cnt_sum = cnt_q;
    if (zero_hit_i && cnt_q != CW'(SAT)) cnt_sum = cnt_q + 1'b1;
  end

  assign sparse_o = (cnt_sum <= CW'(ZERO_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || eval_i) cnt_q <= '0;
    else                      cnt_q <= cnt_sum;
  end
endmodule

// File: rtl/e1_mais_persist.sv
module e1_mais_persist #(
  parameter int PERSIST = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eval_i,
  input  logic sparse_i,
  input  logic hist_clr_i,
  input  logic hard_clr_i,
  output logic alarm_o,
  output logic chg_o
);
  logic hit;
  logic alarm_q, alarm_d, chg_q;

  generate
    if (PERSIST <= 1) begin : g_single
      assign hit = sparse_i;
    end else begin : g_run
      localparam int RW = $clog2(PERSIST);
      logic [RW-1:0] run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         run_q <= '0;
        else if (hist_clr_i) run_q <= '0;
        else if (eval_i) begin
          if (!sparse_i)                       run_q <= '0;
          else if (run_q != RW'(PERSIST - 1))  run_q <= run_q + 1'b1;
        end
      end
      // run_q counts earlier sparse multiframes in the current run
      assign hit = sparse_i && (run_q == RW'(PERSIST - 1));
    end
  endgenerate

  always_comb begin
    alarm_d = alarm_q;
    if (hard_clr_i)  alarm_d = 1'b0;
    else if (eval_i) alarm_d = sparse_i ? (alarm_q | hit) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      chg_q   <= alarm_d ^ alarm_q;
    end
  end

  assign alarm_o = alarm_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/e1_mais_det.sv
module e1_mais_det
  import e1_mais_pkg::*;
#(
  parameter int ZERO_MAX = 3,
  parameter int PERSIST  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cas_en_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic ts16_i,
  input  logic mf_end_i,
  input  logic mf_loss_i,
  output logic alarm_o,
  output logic alarm_chg_o
);
  mais_ctl_t ctl;
  logic      sparse;

  e1_mais_gate u_gate (
    .cas_en_i (cas_en_i),
    .bit_vld_i(bit_vld_i),
    .bit_i    (bit_i),
    .ts16_i   (ts16_i),
    .mf_end_i (mf_end_i),
    .mf_loss_i(mf_loss_i),
    .ctl_o    (ctl)
  );

  e1_mais_zcnt #(.ZERO_MAX(ZERO_MAX)) u_zcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zero_hit_i(ctl.zero_hit),
    .eval_i    (ctl.eval),
    .clr_i     (ctl.hist_clr),
    .sparse_o  (sparse)
  );

  e1_mais_persist #(.PERSIST(PERSIST)) u_persist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eval_i    (ctl.eval),
    .sparse_i  (sparse),
    .hist_clr_i(ctl.hist_clr),
    .hard_clr_i(ctl.hard_clr),
    .alarm_o   (alarm_o),
    .chg_o     (alarm_chg_o)
  );
endmodule

// File: rtl/e1_mais_chk.sv
module e1_mais_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cas_en_i,
  input logic mf_end_i,
  input logic mf_loss_i,
  input logic alarm_o,
  input logic alarm_chg_o
);
  always @(negedge clk_i)
    if (!rst_ni) assert_reset_quiet_R1: assert (!alarm_o && !alarm_chg_o);

  assert_rise_on_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(mf_end_i && cas_en_i && !mf_loss_i));

  assert_fall_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_o) |-> $past(!cas_en_i || (mf_end_i && !mf_loss_i)));

  assert_cas_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_en_i |=> !alarm_o);

  assert_loss_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_en_i && mf_loss_i) |=> $stable(alarm_o));

  assert_chg_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_chg_o == (alarm_o != $past(alarm_o)));
endmodule

bind e1_mais_det e1_mais_chk u_chk (.*);

// File: tb/e1_mais_det_tb_top.sv
`timescale 1ns/1ps
module e1_mais_det_tb_top;
  localparam int ZMAX = 3;
  localparam int NPERS = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cas_en_i = 1'b1, bit_vld_i = 1'b0, bit_i = 1'b1, ts16_i = 1'b0;
  logic mf_end_i = 1'b0, mf_loss_i = 1'b0;
  logic alarm_o, alarm_chg_o;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  bit started = 1'b0;
  bit done = 1'b0;

  // reference model state
  int m_zeros = 0, m_run = 0;
  bit m_alarm = 1'b0, m_chg = 1'b0;

  always #4 clk_i = ~clk_i;

  e1_mais_det dut_i (.*);

  always @(posedge clk_i) begin
    bit old;
    int z;
    started = 1'b1;
    old = m_alarm;
    if (!rst_ni) begin
      m_zeros = 0; m_run = 0; m_alarm = 0;
    end else if (!cas_en_i) begin
      m_zeros = 0; m_run = 0; m_alarm = 0;
    end else if (mf_loss_i) begin
      m_zeros = 0; m_run = 0;
    end else begin
      z = m_zeros + ((bit_vld_i && ts16_i && !bit_i) ? 1 : 0);
      if (mf_end_i) begin
        if (z <= ZMAX) begin
          m_run = m_run + 1;
          if (m_run >= NPERS) begin m_alarm = 1; m_run = NPERS; end
        end else begin
          m_run = 0; m_alarm = 0;
        end
        m_zeros = 0;
      end else m_zeros = z;
    end
    m_chg = rst_ni && (m_alarm != old);
  end

  always @(negedge clk_i) begin
    if (started && !done) begin
      compared++;
      if (alarm_o !== m_alarm || alarm_chg_o !== m_chg) begin
        mismatched++;
        $display("FAIL %s cycle compare: alarm/chg act=%0b%0b exp=%0b%0b",
                 phase, alarm_o, alarm_chg_o, m_alarm, m_chg);
      end
    end
  end

  task automatic check(input string req, input bit exp_a, input bit exp_c);
    compared++;
    if (alarm_o !== exp_a || alarm_chg_o !== exp_c) begin
      mismatched++;
      $display("FAIL %s: alarm/chg act=%0b%0b exp=%0b%0b", req, alarm_o, alarm_chg_o, exp_a, exp_c);
    end
  endtask

  function automatic bit is_zero(input int pos, input int nz);
    for (int k = 0; k < nz; k++) if (((k * 37) % 128) == pos) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_mf(input int nz, input bit noise, input bit gaps,
                        input int loss_at, input bit loss_end);
    int tsb = 0;
    for (int f = 0; f < 16; f++)
      for (int ts = 0; ts < 32; ts++)
        for (int b = 0; b < 8; b++) begin
          bit last;
          last = (f == 15 && ts == 31 && b == 7);
          if (gaps && ts == 16 && b == 3) begin
            @(negedge clk_i);
            bit_vld_i = 0; ts16_i = 1; bit_i = 0; mf_end_i = 0; mf_loss_i = 0;
          end
          @(negedge clk_i);
          bit_vld_i = 1;
          ts16_i    = (ts == 16);
          bit_i     = (ts == 16) ? !is_zero(tsb, nz) : !noise;
          mf_end_i  = last;
          mf_loss_i = ((ts == 16) && (tsb == loss_at)) || (last && loss_end);
          if (ts == 16) tsb++;
        end
    @(negedge clk_i);
    bit_vld_i = 0; ts16_i = 0; bit_i = 1; mf_end_i = 0; mf_loss_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    phase = "R4";
    run_mf(0, 0, 0, -1, 0);   check("R4", 1'b0, 1'b0);
    phase = "R3";
    run_mf(3, 0, 0, -1, 0);   check("R3", 1'b1, 1'b1);
    phase = "R2";
    run_mf(2, 1, 1, -1, 0);   check("R2", 1'b1, 1'b0);
    phase = "R5";
    run_mf(4, 0, 0, -1, 0);   check("R5", 1'b0, 1'b1);
    phase = "R9";
    run_mf(1, 0, 0, -1, 0);   check("R9", 1'b0, 1'b0);
    run_mf(1, 0, 0, -1, 0);   check("R9", 1'b1, 1'b1);
    run_mf(128, 0, 0, -1, 0); check("R9", 1'b0, 1'b1);
    phase = "R7";
    run_mf(0, 0, 0, -1, 0);   check("R7", 1'b0, 1'b0);
    run_mf(0, 0, 0, 60, 0);   check("R7", 1'b0, 1'b0);
    run_mf(0, 0, 0, -1, 0);   check("R7", 1'b1, 1'b1);
    run_mf(5, 0, 0, -1, 1);   check("R7", 1'b1, 1'b0);
    run_mf(0, 0, 0, -1, 0);   check("R7", 1'b1, 1'b0);
    phase = "R6";
    cas_en_i = 0;
    @(negedge clk_i);         check("R6", 1'b0, 1'b1);
    @(negedge clk_i);         check("R8", 1'b0, 1'b0);
    repeat (40) @(negedge clk_i);
    cas_en_i = 1;
    run_mf(0, 0, 0, -1, 0);   check("R6", 1'b0, 1'b0);
    run_mf(0, 0, 0, -1, 0);   check("R6", 1'b1, 1'b1);
    phase = "R8";
    @(negedge clk_i);         check("R8", 1'b1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule